// File: doc/BRIEF.md
# Indexed Chipset Shadow-Memory Controller

This block is the configuration unit of a PC-class chipset. Software reaches it through an 8-bit I/O slave port. It uses an index port to pick a configuration register, a data port to read or write the selected register, and two free scratch bytes. A variant input selects between two reset-default profiles. The variant is sampled while reset is asserted.

From the current register contents, the block decodes routing attributes for the upper memory area from 0xC0000 to 0xFFFFF. For a 20-bit memory address presented on its query input, it reports two routes:
- Read route: on-board RAM or external.
- Write route: RAM, external or blocked.

The area is divided into these pieces:
- the 64 KB BIOS segment;
- four 16 KB adapter-ROM segments in 0xC0000–0xCFFFF;
- eight 16 KB high segments in 0xD0000–0xEFFFF.

Each group has its own enable bits and its own write-protect bits. A global fallback bit decides the routing of segments that are not shadowed. The block also exports an external-cache enable flag.

Top module: `shadow_cfg_unit`

## Requirements
- R1: An I/O write to port 0x0022 loads the index. An I/O write to port 0x0024 stores the byte into the indexed register only when the index lies in 0x20..0x2D. Writes with any other index change no register.
- R2: Reading port 0x0024 with the index outside 0x20..0x2D returns 0xFF. Reading port 0x0022 returns 0xFF. Reading any unmapped port returns 0xFF.
- R3: Port 0x00E1 reads and writes scratch byte 0, and port 0x00E2 reads and writes scratch byte 1. Both reset to 0xFF.
- R4: On reset with variant 0, these registers take these values: 0x20=02, 0x21=20, 0x22=E4, 0x25=F0, 0x26=80, 0x27=B1, 0x28=80, 0x29=10. On reset with variant 1, these registers take these values: 0x20=40, 0x22=84, 0x24=87, 0x25=F1, 0x27=91, 0x28=80, 0x29=10, 0x2A=80, 0x2B=10. Every other register resets to 0x00.
- R5: For addresses 0xF0000–0xFFFFF, bit 7 of reg 0x22 set gives read external and write RAM. Bit 7 clear gives read RAM and write blocked.
- R6: High segment i (base 0xD0000 + i·0x4000, i = 0..7) is shadowed when bit i of reg 0x23 is set and its group enable is set. The group enable is reg 0x22 bit 6 for i = 0..3 and bit 5 for i = 4..7. A shadowed segment reads from RAM.
- R7: The write-protect bit is reg 0x22 bit 4 for high segments 0..3 and bit 3 for segments 4..7. When this bit is set, writes to a shadowed segment are blocked; otherwise they go to RAM.
- R8: Adapter segment i (base 0xC0000 + i·0x4000, i = 0..3) is shadowed when reg 0x26 bit 4 and bit i are both set. It then reads from RAM. Its writes are blocked if reg 0x26 bit 5 is set, otherwise they go to RAM.
- R9: For a segment in 0xC0000–0xEFFFF that is not shadowed, the routing depends on reg 0x26 bit 6. With the bit set, reads go external and writes follow that segment's write-protect bit (blocked or RAM). With the bit clear, reads and writes both go external.
- R10: The ext_cache_en output equals bit 4 of reg 0x21.
- R11: Route codes are 00 RAM, 01 external, 10 blocked; the read route never shows 10, and neither route shows 11. Addresses below 0xC0000 report RAM for both routes.
- R12: Route and cache outputs are combinational in the query address. They show a register write from the first clock cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Reset profile select, sampled during reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 20 | Memory address to classify |
| rd_route | output | 2 | Read route code for mem_addr |
| wr_route | output | 2 | Write route code for mem_addr |
| ext_cache_en | output | 1 | External cache enable |

## Verification
The hardest situation to reach from the ports is a high or adapter segment whose shadow bit is set while its group enable is clear. In that case the fallback bit, rather than the segment bit, must decide the routing, and the write-protect bit of the opposite group must not leak in. Directed register settings set alternating segment bits with one group enable off and the fallback bit in both states. Each setting is followed by a sweep of both ends of every 16 KB segment. Random sequences of index and data writes, including indices just outside the window, then mix those bits freely. After each such sequence, the bench queries random addresses and compares them against a bench-side routing function.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic [1:0] {
    RT_RAM = 2'b00,
    RT_EXT = 2'b01,
    RT_BLK = 2'b10
  } route_t;

  localparam logic [7:0] CFG_FIRST = 8'h20;
  localparam int         CFG_COUNT = 14;

  // Reset profile by absolute register index; alt selects the second profile.
  function automatic logic [7:0] reset_value(input logic alt, input logic [7:0] idx);
    logic [7:0] v;
    v = 8'h00;
    if (!alt) begin
      case (idx)
        8'h20: v = 8'h02;
        8'h21: v = 8'h20;
        8'h22: v = 8'hE4;
        8'h25: v = 8'hF0;
        8'h26: v = 8'h80;
        8'h27: v = 8'hB1;
        8'h28: v = 8'h80;
        8'h29: v = 8'h10;
        default: v = 8'h00;
      endcase
    end else begin
      case (idx)
        8'h20: v = 8'h40;
        8'h22: v = 8'h84;
        8'h24: v = 8'h87;
        8'h25: v = 8'hF1;
        8'h27: v = 8'h91;
        8'h28: v = 8'h80;
        8'h29: v = 8'h10;
        8'h2A: v = 8'h80;
        8'h2B: v = 8'h10;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import shadow_pkg::*;
#(
  parameter logic [15:0] PORT_INDEX = 16'h0022,
  parameter logic [15:0] PORT_DATA  = 16'h0024,
  parameter logic [15:0] PORT_SCR0  = 16'h00E1,
  parameter logic [15:0] PORT_SCR1  = 16'h00E2,
  parameter logic [7:0]  IDX_LO     = CFG_FIRST,
  parameter int          NREG       = CFG_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              variant_sel,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic [7:0]        idx_q,
  output logic [8*NREG-1:0] cfg_flat
);
  localparam logic [7:0] IDX_HI = 8'(int'(IDX_LO) + NREG - 1);
  localparam int         OW     = $clog2(NREG);

  logic [7:0] regs [NREG];
  logic [7:0] scr0_q, scr1_q;
  logic       in_win;
  logic [7:0] off_full;
  logic [OW-1:0] off;

  assign in_win   = (idx_q >= IDX_LO) && (idx_q <= IDX_HI);
  assign off_full = idx_q - IDX_LO;
  assign off      = off_full[OW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= 8'h00;
      scr0_q <= 8'hFF;
      scr1_q <= 8'hFF;
      for (int k = 0; k < NREG; k++)
        regs[k] <= reset_value(variant_sel, 8'(int'(IDX_LO) + k));
    end else if (io_wr) begin
      case (io_addr)
        PORT_INDEX: idx_q <= io_wdata;
        PORT_DATA:  if (in_win) regs[off] <= io_wdata;
        PORT_SCR0:  scr0_q <= io_wdata;
        PORT_SCR1:  scr1_q <= io_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    case (io_addr)
      PORT_DATA: if (in_win) io_rdata = regs[off];
      PORT_SCR0: io_rdata = scr0_q;
      PORT_SCR1: io_rdata = scr1_q;
      default:   io_rdata = 8'hFF;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_flat[8*g +: 8] = regs[g];
  end
endmodule

// File: rtl/seg_attr_table.sv
module seg_attr_table
  import shadow_pkg::*;
#(
  parameter int N_ADP = 4,
  parameter int N_HI  = 8
) (
  input  logic [7:0]                 hi_ctl,
  input  logic [7:0]                 hi_mask,
  input  logic [7:0]                 adp_ctl,
  output logic [2*(N_ADP+N_HI)-1:0]  rd_tab,
  output logic [2*(N_ADP+N_HI)-1:0]  wr_tab
);
  localparam int NSEG   = N_ADP + N_HI;
  localparam int HALF   = N_HI / 2;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic shadowed, wprot;
    if (g < N_ADP) begin : g_adp
      assign shadowed = adp_ctl[4] & adp_ctl[g];
      assign wprot    = adp_ctl[5];
    end else begin : g_hi
      localparam int J = g - N_ADP;
      if (J < HALF) begin : g_low
        assign shadowed = hi_ctl[6] & hi_mask[J];
        assign wprot    = hi_ctl[4];
      end else begin : g_up
        assign shadowed = hi_ctl[5] & hi_mask[J];
        assign wprot    = hi_ctl[3];
      end
    end

    route_t rd_r, wr_r;
    always_comb begin
      if (shadowed) begin
        rd_r = RT_RAM;
        wr_r = wprot ? RT_BLK : RT_RAM;
      end else if (adp_ctl[6]) begin
        rd_r = RT_EXT;
        wr_r = wprot ? RT_BLK : RT_RAM;
      end else begin
        rd_r = RT_EXT;
        wr_r = RT_EXT;
      end
    end
    assign rd_tab[2*g +: 2] = rd_r;
    assign wr_tab[2*g +: 2] = wr_r;
  end
endmodule

// File: rtl/route_lookup.sv
module route_lookup
  import shadow_pkg::*;
#(
  parameter int N_ADP = 4,
  parameter int N_HI  = 8
) (
  input  logic [19:0]                mem_addr,
  input  logic                       bios_ext,
  input  logic [2*(N_ADP+N_HI)-1:0]  rd_tab,
  input  logic [2*(N_ADP+N_HI)-1:0]  wr_tab,
  output logic [1:0]                 rd_route,
  output logic [1:0]                 wr_route
);
  localparam int NSEG = N_ADP + N_HI;
  localparam int SW   = $clog2(NSEG);

  logic [SW-1:0] sel;

  always_comb begin
    rd_route = RT_RAM;
    wr_route = RT_RAM;
    sel      = '0;
    case (mem_addr[19:16])
      4'hF: begin
        rd_route = bios_ext ? RT_EXT : RT_RAM;
        wr_route = bios_ext ? RT_RAM : RT_BLK;
      end
      4'hC: begin
        sel      = SW'(mem_addr[15:14]);
        rd_route = rd_tab[2*sel +: 2];
        wr_route = wr_tab[2*sel +: 2];
      end
      4'hD, 4'hE: begin
        sel      = SW'(N_ADP + int'({mem_addr[17], mem_addr[15:14]}));
        rd_route = rd_tab[2*sel +: 2];
        wr_route = wr_tab[2*sel +: 2];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shadow_cfg_unit.sv
module shadow_cfg_unit
  import shadow_pkg::*;
#(
  parameter logic [15:0] PORT_INDEX = 16'h0022,
  parameter logic [15:0] PORT_DATA  = 16'h0024,
  parameter logic [15:0] PORT_SCR0  = 16'h00E1,
  parameter logic [15:0] PORT_SCR1  = 16'h00E2,
  parameter int          N_ADP      = 4,
  parameter int          N_HI       = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        variant_sel,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  input  logic [19:0] mem_addr,
  output logic [1:0]  rd_route,
  output logic [1:0]  wr_route,
  output logic        ext_cache_en
);
  localparam int NREG  = CFG_COUNT;
  localparam int NSEG  = N_ADP + N_HI;
  localparam int O_CCH = 'h21 - int'(CFG_FIRST);
  localparam int O_HIC = 'h22 - int'(CFG_FIRST);
  localparam int O_HIM = 'h23 - int'(CFG_FIRST);
  localparam int O_ADP = 'h26 - int'(CFG_FIRST);

  logic [7:0]        idx_q;
  logic [8*NREG-1:0] cfg_flat;
  logic [2*NSEG-1:0] rd_tab, wr_tab;
  logic [7:0]        cch_reg, hi_ctl, hi_mask, adp_ctl;
  logic              rd_unused;

  assign rd_unused = io_rd;

  cfg_regfile #(
    .PORT_INDEX(PORT_INDEX), .PORT_DATA(PORT_DATA),
    .PORT_SCR0(PORT_SCR0),   .PORT_SCR1(PORT_SCR1),
    .IDX_LO(CFG_FIRST),      .NREG(NREG)
  ) u_regs (
    .clk(clk), .rst(rst), .variant_sel(variant_sel),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rdata(io_rdata), .idx_q(idx_q), .cfg_flat(cfg_flat)
  );

  assign cch_reg = cfg_flat[8*O_CCH +: 8];
  assign hi_ctl  = cfg_flat[8*O_HIC +: 8];
  assign hi_mask = cfg_flat[8*O_HIM +: 8];
  assign adp_ctl = cfg_flat[8*O_ADP +: 8];

  seg_attr_table #(.N_ADP(N_ADP), .N_HI(N_HI)) u_table (
    .hi_ctl(hi_ctl), .hi_mask(hi_mask), .adp_ctl(adp_ctl),
    .rd_tab(rd_tab), .wr_tab(wr_tab)
  );

  route_lookup #(.N_ADP(N_ADP), .N_HI(N_HI)) u_lookup (
    .mem_addr(mem_addr), .bios_ext(hi_ctl[7]),
    .rd_tab(rd_tab), .wr_tab(wr_tab),
    .rd_route(rd_route), .wr_route(wr_route)
  );

  assign ext_cache_en = cch_reg[4];
endmodule

// File: rtl/shadow_cfg_checker.sv
module shadow_cfg_checker #(
  parameter logic [15:0] PORT_INDEX = 16'h0022,
  parameter logic [15:0] PORT_DATA  = 16'h0024,
  parameter int          NBITS      = 112
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      io_addr,
  input logic [7:0]       io_wdata,
  input logic             io_wr,
  input logic             io_rd,
  input logic [7:0]       io_rdata,
  input logic [19:0]      mem_addr,
  input logic [1:0]       rd_route,
  input logic [1:0]       wr_route,
  input logic             ext_cache_en,
  input logic [7:0]       idx_q,
  input logic [NBITS-1:0] cfg_flat
);
  a_r11_low_ram: assert property (@(posedge clk) disable iff (rst)
    (mem_addr < 20'hC0000) |-> (rd_route == 2'b00 && wr_route == 2'b00));

  a_r11_codes: assert property (@(posedge clk) disable iff (rst)
    (rd_route inside {2'b00, 2'b01}) && (wr_route != 2'b11));

  a_r2_index_ff: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == PORT_INDEX) |-> (io_rdata == 8'hFF));

  a_r10_cache_follow: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == PORT_DATA && idx_q == 8'h21) |=> (ext_cache_en == $past(io_wdata[4])));

  a_r1_outside_window: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == PORT_DATA && (idx_q < 8'h20 || idx_q > 8'h2D)) |=> $stable(cfg_flat));

  a_r5_bios_pair: assert property (@(posedge clk) disable iff (rst)
    (mem_addr[19:16] == 4'hF) |-> ((rd_route == 2'b00) == (wr_route == 2'b10)));
endmodule

bind shadow_cfg_unit shadow_cfg_checker #(
  .PORT_INDEX(PORT_INDEX), .PORT_DATA(PORT_DATA), .NBITS(8*NREG)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
  .io_rd(io_rd), .io_rdata(io_rdata), .mem_addr(mem_addr), .rd_route(rd_route),
  .wr_route(wr_route), .ext_cache_en(ext_cache_en), .idx_q(idx_q), .cfg_flat(cfg_flat)
);

// File: tb/sim_shadow_cfg_unit.sv
module sim_shadow_cfg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        variant_sel = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = 20'h00000;
  logic [1:0]  rd_route, wr_route;
  logic        ext_cache_en;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_regs [14];
  logic [7:0] m_scr [2];
  logic [7:0] m_idx;

  always #4 clk = ~clk;

  shadow_cfg_unit u0 (
    .clk(clk), .rst(rst), .variant_sel(variant_sel),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .mem_addr(mem_addr), .rd_route(rd_route),
    .wr_route(wr_route), .ext_cache_en(ext_cache_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // R4 reset profiles written out independently
  task automatic model_reset(input logic alt);
    for (int k = 0; k < 14; k++) m_regs[k] = 8'h00;
    if (!alt) begin
      m_regs[0] = 8'h02; m_regs[1] = 8'h20; m_regs[2] = 8'hE4; m_regs[5] = 8'hF0;
      m_regs[6] = 8'h80; m_regs[7] = 8'hB1; m_regs[8] = 8'h80; m_regs[9] = 8'h10;
    end else begin
      m_regs[0] = 8'h40; m_regs[2] = 8'h84; m_regs[4] = 8'h87; m_regs[5] = 8'hF1;
      m_regs[7] = 8'h91; m_regs[8] = 8'h80; m_regs[9] = 8'h10; m_regs[10] = 8'h80;
      m_regs[11] = 8'h10;
    end
    m_scr[0] = 8'hFF; m_scr[1] = 8'hFF; m_idx = 8'h00;
  endtask

  function automatic logic [3:0] exp_route(input logic [19:0] a);
    logic [7:0] r22, r23, r26;
    int seg;
    logic sh, wp, up;
    r22 = m_regs[2]; r23 = m_regs[3]; r26 = m_regs[6];
    if (a < 20'hC0000) return 4'b0000;
    if (a >= 20'hF0000) return r22[7] ? 4'b0100 : 4'b0010;
    if (a < 20'hD0000) begin
      seg = int'((a - 20'hC0000) >> 14);
      sh = r26[4] && r26[seg];
      wp = r26[5];
    end else begin
      seg = int'((a - 20'hD0000) >> 14);
      up = (seg >= 4);
      sh = (up ? r22[5] : r22[6]) && r23[seg];
      wp = up ? r22[3] : r22[4];
    end
    if (sh) return {2'b00, wp ? 2'b10 : 2'b00};
    if (r26[6]) return {2'b01, wp ? 2'b10 : 2'b00};
    return 4'b0101;
  endfunction

  function automatic string tag_of(input logic [19:0] a);
    if (a < 20'hC0000) return "R11";
    if (a >= 20'hF0000) return "R5";
    if (a < 20'hD0000) return "R8 R9";
    return "R6 R7 R9";
  endfunction

  task automatic do_reset(input logic alt);
    @(negedge clk);
    variant_sel = alt; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset(alt);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    case (a)
      16'h0022: m_idx = d;
      16'h0024: if (m_idx >= 8'h20 && m_idx <= 8'h2D) m_regs[m_idx - 8'h20] = d;
      16'h00E1: m_scr[0] = d;
      16'h00E2: m_scr[1] = d;
      default: ;
    endcase
  endtask

  task automatic io_read_chk(input logic [15:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    e = 8'hFF;
    if (a == 16'h0024 && m_idx >= 8'h20 && m_idx <= 8'h2D) e = m_regs[m_idx - 8'h20];
    if (a == 16'h00E1) e = m_scr[0];
    if (a == 16'h00E2) e = m_scr[1];
    chk(req, io_rdata, e);
    io_rd = 1'b0;
  endtask

  task automatic route_chk(input logic [19:0] a);
    logic [3:0] e;
    @(negedge clk);
    mem_addr = a;
    #1;
    e = exp_route(a);
    chk({tag_of(a), " rd"}, {6'd0, rd_route}, {6'd0, e[3:2]});
    chk({tag_of(a), " wr"}, {6'd0, wr_route}, {6'd0, e[1:0]});
  endtask

  task automatic sweep();
    for (int s = 0; s < 24; s++) begin
      route_chk(20'hA0000 + 20'(s) * 20'h4000);
      route_chk(20'hA0000 + 20'(s) * 20'h4000 + 20'h3FFF);
    end
  endtask

  task automatic check_all_regs(input string req);
    for (int k = 8'h20; k <= 8'h2D; k++) begin
      io_write(16'h0022, 8'(k));
      io_read_chk(16'h0024, req);
    end
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
    io_write(16'h0022, idx);
    io_write(16'h0024, v);
  endtask

  task automatic cache_chk(input string req);
    @(negedge clk);
    #1;
    chk(req, {7'd0, ext_cache_en}, {7'd0, m_regs[1][4]});
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    // R4 profile A, R3 scratch reset, R2 index port, R10 cache reset state
    do_reset(1'b0);
    io_read_chk(16'h00E1, "R3 reset scr0");
    io_read_chk(16'h00E2, "R3 reset scr1");
    check_all_regs("R4 profile A");
    io_read_chk(16'h0022, "R2 index port");
    cache_chk("R10 reset A");
    sweep();
    // R4 profile B
    do_reset(1'b1);
    check_all_regs("R4 profile B");
    cache_chk("R10 reset B");
    sweep();
    // R1/R2 out-of-window writes and reads
    set_reg(8'h2E, 8'h55);
    io_read_chk(16'h0024, "R2 idx 2E");
    set_reg(8'h1F, 8'h66);
    io_read_chk(16'h0024, "R2 idx 1F");
    io_read_chk(16'h0030, "R2 unmapped");
    check_all_regs("R1 untouched");
    // R10 / R12 cache follows next cycle
    set_reg(8'h21, 8'h10);
    cache_chk("R10 R12 cache set");
    set_reg(8'h21, 8'hEF);
    cache_chk("R10 R12 cache clear");
    // R3 scratch
    io_write(16'h00E1, 8'h5A);
    io_write(16'h00E2, 8'hA5);
    io_read_chk(16'h00E1, "R3 scr0");
    io_read_chk(16'h00E2, "R3 scr1");
    // R6 R7 R8 R9 directed shadow settings
    set_reg(8'h22, 8'h58); set_reg(8'h23, 8'hA5); set_reg(8'h26, 8'h1A);
    route_chk(20'hD0000);  // R12: first query after the write
    sweep();
    set_reg(8'h22, 8'h38); set_reg(8'h26, 8'h75);
    sweep();
    set_reg(8'h22, 8'h60); set_reg(8'h23, 8'hFF); set_reg(8'h26, 8'h3F);
    sweep();
    set_reg(8'h22, 8'h00); set_reg(8'h26, 8'h40);
    sweep();
    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: io_write(16'h0022, 8'($urandom_range(8'h1C, 8'h2F)));
        1: io_write(16'h0024, 8'($urandom));
        2: io_read_chk(16'h0024, "R1 R2 random read");
        3: io_write($urandom_range(0, 1) ? 16'h00E1 : 16'h00E2, 8'($urandom));
        4: cache_chk("R10 random");
        default: route_chk(20'($urandom_range(20'h90000, 20'hFFFFF)));
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule